// File: doc/BRIEF.md
# Register-File Spread-Spectrum Correlator

This block despreads a direct-sequence spread-spectrum sample stream by computing, for every incoming sample, the full-length correlation against a binary code of length L = 2^M − 1. Multi-bit samples are never moved once written. Each new sample lands in exactly one storage entry, chosen by a one-hot write pointer that walks the entries in a ring. The single-bit code is kept in its own circular register, and that register rotates by one place per sample. Each stored sample therefore always meets the coefficient that matches its age.

Samples arrive on a shared write bus that carries bus-invert coding. The sender complements a word and raises an invert line when more than half of the bus bits would otherwise toggle. The block does not decode the word at the write. It stores the raw bus word together with its invert flag. The per-entry sign selection merges that flag with the coefficient sign, and a single carry term completes the two's complement. A plain binary adder tree, either pipelined per level or built as one combinational stage with a result register, produces one correlation per written sample.

Top module: `rfc_correlator`

## Requirements
- R1: After reset, corr_valid is low, corr_out is zero, every stored sample is zero, the write pointer selects entry 0 and the code ring holds its start state. The first correlation after reset therefore equals h0·x for the first sample x.
- R2: Each write loads only the entry selected by the one-hot pointer, and the pointer then advances by one place around a ring of L entries. The correlation window is always the newest L samples, and the oldest sample is overwritten first.
- R3: The code ring rotates by exactly one place per write and holds its state on cycles without a write, so that coefficient h_i always applies to the sample written i writes earlier.
- R4: When wr_inv is 1, wr_bus carries the bitwise complement of the true sample. The result then equals the result for the true sample sent uncoded.
- R5: For write k, corr_out = Σ_{i=0..L−1} h_i·x_{k−i}, where h_i = +1 when CODE[i] is 0 and −1 when CODE[i] is 1. Samples are signed two's complement of SW bits, and samples older than the first write after reset count as 0.
- R6: corr_valid pulses for one cycle per write, exactly LAT rising edges after the edge that takes the write (LAT = M with PIPE = 1, LAT = 1 with PIPE = 0). Back-to-back writes give one result per cycle, and corr_out does not change while corr_valid is low.
- R7: The output width is SW + M + 1 bits. A window in which every term reaches its largest magnitude, including the most negative sample multiplied by −1, gives the exact result.
- R8: While wr_en is low, wr_bus and wr_inv are ignored: the result, the pointer and the stored samples are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | One sample write this cycle |
| wr_bus | input | SW | Sample word as sent on the bus-invert coded bus |
| wr_inv | input | 1 | 1: wr_bus holds the complement of the sample |
| corr_valid | output | 1 | Result strobe, one cycle per write |
| corr_out | output | SW+M+1 | Signed correlation result |

## Verification
A pointer or code ring that slips by one place puts every sample against the wrong coefficient. The first result after the slip then departs from the convolution, so a write-by-write comparison against the convolution of the stream exposes it within LAT cycles of the faulty write. A stored invert flag that is lost or applied twice shows up in the first result that includes that entry. It stays in every result until the entry is overwritten L writes later. A wrong latency or a missing carry term shows at once in the valid strobe timing or in the value after a single write following reset.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
   // Number of rising edges from the write edge to the result strobe.
   function automatic int tree_latency(input int m, input int pipe);
      return (pipe != 0) ? m : 1;
   endfunction

   // Result width: sign-extended product (SW+1) grown by one bit per tree level.
   function automatic int result_width(input int sw, input int m);
      return sw + 1 + m;
   endfunction
endpackage

// File: rtl/rfc_sample_bank.sv
module rfc_sample_bank #(
   parameter int L  = 7,
   parameter int SW = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [SW-1:0]   wr_bus,
   input  logic            wr_inv,
   output logic [L-1:0]    ptr,
   output logic [L*SW-1:0] raw_flat,
   output logic [L-1:0]    inv_flags
);
   // One-hot write pointer, starts at entry 0.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr <= L'(1);
      else if (wr_en)
         ptr <= {ptr[L-2:0], ptr[L-1]};
   end

   for (genvar e = 0; e < L; e++) begin : g_entry
      logic [SW-1:0] word_q;
      logic          inv_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q <= '0;
            inv_q  <= 1'b0;
         end else if (wr_en && ptr[e]) begin
            word_q <= wr_bus;
            inv_q  <= wr_inv;
         end
      end
      assign raw_flat[e*SW +: SW] = word_q;
      assign inv_flags[e]         = inv_q;
   end
endmodule

// File: rtl/rfc_code_ring.sv
module rfc_code_ring #(
   parameter int           L    = 7,
   parameter logic [L-1:0] CODE = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   output logic [L-1:0] coef
);
   // Start state: entry e holds CODE[L-1-e], so that after the first
   // write entry 0 (the newest sample) meets CODE[0].
   logic [L-1:0] start_state;
   for (genvar e = 0; e < L; e++) begin : g_start
      assign start_state[e] = CODE[L-1-e];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         coef <= start_state;
      else if (step)
         coef <= {coef[L-2:0], coef[L-1]};
   end
endmodule

// File: rtl/rfc_adder_tree.sv
module rfc_adder_tree #(
   parameter int M    = 3,
   parameter int LW   = 7,
   parameter int PIPE = 1,
   localparam int L   = (2 ** M) - 1,
   localparam int NP  = 2 ** M,
   localparam int OW  = LW + M
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [L*LW-1:0] leaves,
   output logic [OW-1:0]   root
);
   logic [OW-1:0] lf [NP];

   for (genvar j = 0; j < NP; j++) begin : g_leaf
      if (j < L) begin : g_real
         assign lf[j] = {{M{leaves[j*LW+LW-1]}}, leaves[j*LW +: LW]};
      end else begin : g_pad
         assign lf[j] = '0;
      end
   end

   if (PIPE != 0) begin : g_pipe
      // Heap layout: node i sums nodes 2i and 2i+1, leaves at NP..2NP-1.
      logic [OW-1:0] nd   [1:NP-1];
      logic [OW-1:0] view [1:2*NP-1];
      always_comb begin
         for (int i = 1; i < NP; i++) view[i] = nd[i];
         for (int j = 0; j < NP; j++) view[NP+j] = lf[j];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 1; i < NP; i++) nd[i] <= '0;
         end else begin
            for (int i = 1; i < NP; i++) nd[i] <= view[2*i] + view[2*i+1];
         end
      end
      assign root = nd[1];
   end else begin : g_flat
      logic [OW-1:0] acc [NP];
      logic [OW-1:0] sum_q;
      always_comb begin
         for (int j = 0; j < NP; j++) acc[j] = lf[j];
         for (int w = NP / 2; w >= 1; w = w / 2) begin
            for (int n = 0; n < w; n++) acc[n] = acc[2*n] + acc[2*n+1];
         end
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sum_q <= '0;
         else        sum_q <= acc[0];
      end
      assign root = sum_q;
   end
endmodule

// File: rtl/rfc_correlator.sv
module rfc_correlator
   import rfc_pkg::*;
#(
   parameter int                M    = 3,
   parameter int                SW   = 6,
   parameter int                PIPE = 1,
   parameter logic [2**M-2:0]   CODE = 7'b0010111
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [SW-1:0]        wr_bus,
   input  logic                 wr_inv,
   output logic                 corr_valid,
   output logic signed [SW+M:0] corr_out
);
   localparam int L   = (2 ** M) - 1;
   localparam int LW  = SW + 1;
   localparam int OW  = result_width(SW, M);
   localparam int LAT = tree_latency(M, PIPE);

   if (M < 2 || M > 10) begin : g_bad_m
      $error("rfc_correlator: M must lie in 2..10");
   end
   if (SW < 2) begin : g_bad_sw
      $error("rfc_correlator: SW must be at least 2");
   end
   if (PIPE != 0 && PIPE != 1) begin : g_bad_pipe
      $error("rfc_correlator: PIPE must be 0 or 1");
   end

   logic [L-1:0]    wr_ptr;
   logic [L*SW-1:0] raw_flat;
   logic [L-1:0]    inv_flags;
   logic [L-1:0]    code_bits;
   logic [L*LW-1:0] leaves;
   logic [OW-1:0]   root;
   logic [LAT:0]    vpipe;

   rfc_sample_bank #(.L(L), .SW(SW)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_bus    (wr_bus),
      .wr_inv    (wr_inv),
      .ptr       (wr_ptr),
      .raw_flat  (raw_flat),
      .inv_flags (inv_flags)
   );

   rfc_code_ring #(.L(L), .CODE(CODE)) u_ring (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (wr_en),
      .coef  (code_bits)
   );

   // Sign select with bus-invert merged in: true product is
   // (code ^ inv ? ~raw : raw) + code, all sign-extended to LW bits.
   for (genvar e = 0; e < L; e++) begin : g_mult
      logic [SW-1:0] raw;
      logic [SW-1:0] sel;
      assign raw = raw_flat[e*SW +: SW];
      assign sel = (code_bits[e] ^ inv_flags[e]) ? ~raw : raw;
      assign leaves[e*LW +: LW] = {sel[SW-1], sel} + {{SW{1'b0}}, code_bits[e]};
   end

   rfc_adder_tree #(.M(M), .LW(LW), .PIPE(PIPE)) u_tree (
      .clk    (clk),
      .rst_n  (rst_n),
      .leaves (leaves),
      .root   (root)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vpipe <= '0;
      else        vpipe <= {vpipe[LAT-1:0], wr_en};
   end

   assign corr_valid = vpipe[LAT];
   assign corr_out   = $signed(root);
endmodule

// File: rtl/rfc_checker.sv
module rfc_checker #(
   parameter int L   = 7,
   parameter int LAT = 3,
   parameter int OW  = 10
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic [L-1:0]  ptr,
   input logic [L-1:0]  ring,
   input logic          corr_valid,
   input logic [OW-1:0] corr_out
);
   logic [7:0] pend;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else        pend <= pend + {7'd0, wr_en} - {7'd0, corr_valid};
   end

   assert_ptr_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(ptr) == 1);

   assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ptr == {$past(ptr[L-2:0]), $past(ptr[L-1])});

   assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(ptr));

   assert_ring_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ring == {$past(ring[L-2:0]), $past(ring[L-1])});

   assert_ring_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(ring));

   assert_valid_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
      corr_valid |-> pend != 8'd0);

   assert_pend_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pend <= 8'(LAT + 1));

   assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !corr_valid |-> $stable(corr_out));
endmodule

bind rfc_correlator rfc_checker #(.L(L), .LAT(LAT), .OW(OW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .ptr        (wr_ptr),
   .ring       (code_bits),
   .corr_valid (corr_valid),
   .corr_out   (root)
);

// File: tb/rfc_correlator_test.sv
`timescale 1ns/1ps
module rfc_correlator_test;
   localparam int M    = 3;
   localparam int SW   = 6;
   localparam int L    = 7;
   localparam int LAT  = 3;
   localparam logic [6:0] CODE = 7'b0010111;
   localparam int NV   = 16;
   localparam logic signed [5:0] VEC [NV] = '{
      6'sd5, -6'sd3, 6'sd31, -6'sd32, 6'sd0, 6'sd17, -6'sd1, 6'sd12,
      -6'sd20, 6'sd9, 6'sd30, -6'sd31, 6'sd2, -6'sd8, 6'sd25, -6'sd16};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [SW-1:0] wr_bus = '0;
   logic wr_inv = 1'b0;
   logic corr_valid;
   logic signed [SW+M:0] corr_out;

   int total = 0;
   int bad = 0;
   int hist [L];
   bit finished = 1'b0;

   always #10 clk = ~clk;

   rfc_correlator #(.M(M), .SW(SW), .PIPE(1), .CODE(CODE)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bus(wr_bus),
      .wr_inv(wr_inv), .corr_valid(corr_valid), .corr_out(corr_out));

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int model();
      int s = 0;
      for (int i = 0; i < L; i++) s += CODE[i] ? -hist[i] : hist[i];
      return s;
   endfunction

   function automatic int ones(input logic [SW-1:0] v);
      int c = 0;
      for (int b = 0; b < SW; b++) c += int'(v[b]);
      return c;
   endfunction

   // Called at a negedge: bus-invert encode against current bus lines.
   task automatic drive_write(input logic signed [SW-1:0] x, input bit force_inv);
      logic [SW-1:0] w = x;
      if (force_inv || ones(wr_bus ^ w) > SW / 2) begin
         wr_bus = ~w;
         wr_inv = 1'b1;
      end else begin
         wr_bus = w;
         wr_inv = 1'b0;
      end
      wr_en = 1'b1;
      for (int i = L - 1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = int'(x);
   endtask

   task automatic write_and_check(input logic signed [SW-1:0] x, input bit force_inv,
                                  input string req);
      int exp;
      @(negedge clk);
      drive_write(x, force_inv);
      exp = model();
      @(negedge clk);
      wr_en = 1'b0;
      repeat (LAT - 1) @(negedge clk);
      check({req, " R6 early valid"}, int'(corr_valid), 0);
      @(negedge clk);
      check({req, " R6 valid"}, int'(corr_valid), 1);
      check(req, int'(corr_out), exp);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      wr_en = 1'b0;
      for (int i = 0; i < L; i++) hist[i] = 0;
      @(negedge clk);
      check("R1 reset valid", int'(corr_valid), 0);
      check("R1 reset out", int'(corr_out), 0);
      rst_n = 1'b1;
   endtask

   initial begin
      #(200000 * 20);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int exp_b2b [10];
      int held;
      for (int i = 0; i < L; i++) hist[i] = 0;
      repeat (2) @(negedge clk);
      do_reset();

      // R1: single write after reset gives h0*x (CODE[0]=1 -> -x)
      write_and_check(6'sd13, 1'b0, "R1 first write");

      // Table walk: R5 convolution, R4 via encoder, R2 wrap past L entries
      for (int v = 0; v < NV; v++) begin
         write_and_check(VEC[v], 1'b0, "R5 table");
      end

      // R4: same sample forced inverted vs plain encoding
      write_and_check(-6'sd7, 1'b1, "R4 forced invert");
      write_and_check(6'sd21, 1'b1, "R4 forced invert");

      // R6: back-to-back writes, one result per cycle
      for (int s = 0; s < 10 + LAT + 1; s++) begin
         @(negedge clk);
         if (s >= LAT + 1) begin
            check("R6 b2b valid", int'(corr_valid), 1);
            check("R5 b2b value", int'(corr_out), exp_b2b[s-LAT-1]);
         end else begin
            check("R6 b2b idle", int'(corr_valid), 0);
         end
         if (s < 10) begin
            drive_write(VEC[(s * 3) % NV], 1'b0);
            exp_b2b[s] = model();
         end else begin
            wr_en = 1'b0;
         end
      end

      // R8/R3: bus activity without wr_en is ignored
      @(negedge clk);
      held = int'(corr_out);
      for (int g = 0; g < 6; g++) begin
         wr_bus = SW'(g * 11 + 5);
         wr_inv = g[0];
         @(negedge clk);
         check("R8 idle valid", int'(corr_valid), 0);
         check("R8 idle hold", int'(corr_out), held);
      end
      write_and_check(-6'sd4, 1'b0, "R3 R8 after idle");

      // R7: every term at full magnitude
      for (int i = L - 1; i >= 0; i--) begin
         write_and_check(CODE[i] ? -6'sd32 : 6'sd31, 1'b0, "R7 extreme");
      end
      check("R7 extreme value", int'(corr_out), 4 * 32 + 3 * 31);

      // R1/R2: reset mid-stream clears samples, pointer and code ring
      do_reset();
      write_and_check(6'sd9, 1'b0, "R1 after reset");
      check("R1 h0 value", int'(corr_out), -9);
      for (int i = 0; i < L; i++) write_and_check(6'sd1, 1'b0, "R2 window");
      check("R2 oldest dropped", int'(corr_out), 1 * (3 - 4));

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule